// File: doc/BRIEF.md
# Programmable Display Line-Period Generator

This block sets the horizontal line time of a display driver that runs from its own oscillator. A gated oscillator enable is first slowed by a selectable power-of-two prescaler to form the internal operation clock. A line counter then counts a programmed number of those internal clocks and emits a single-cycle strobe each time a line ends. When the driver is in RGB-interface operation, the prescaler is skipped, and the counter advances on every oscillator enable.

Both settings sit in one 16-bit control word, which is written and read through a simple register port. A write with a line length below the legal minimum is refused. In that case the old length stays in force and a sticky error flag is set. New settings are copied into the active timing state only when a line ends, so no line is ever cut short or stretched.

Top module: `lpg_top`

## Requirements
- R1: After reset, the control word reads 0x0019 (divide code 0, length 25), the error flag is 0 and the line strobe is 0.
- R2: In the control word, bits 9:8 hold the divide code and bits 4:0 hold the clocks-per-line code. Every other bit reads as 0, whatever was written.
- R3: With a length code L from 16 to 31, one line lasts exactly L internal clocks.
- R4: Divide codes 0, 1, 2 and 3 make one internal clock last 1, 2, 4 and 8 oscillator enables.
- R5: A write whose length code is below 16 leaves the stored length unchanged but still updates the divide code. It also sets the error flag, which stays 1 until reset.
- R6: A new length or divide code first affects the line that starts after the current line ends. The line in progress keeps its old duration.
- R7: While the RGB-mode input is 1, the divide code has no effect and every oscillator enable counts as one internal clock.
- R8: The line strobe is high for exactly one clock cycle per line.
- R9: Timing advances only on cycles with the oscillator enable high. With the enable high every other cycle, the line period in clock cycles doubles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| osc_en | input | 1 | Oscillator clock enable |
| rgb_mode | input | 1 | 1 selects RGB-interface operation (prescaler bypassed) |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 16 | Control word write data |
| reg_rdata | output | 16 | Control word read data |
| line_pulse | output | 1 | One-cycle strobe marking the start of each line |
| len_err | output | 1 | Sticky flag: a prohibited length code was written |

## Verification
The bench builds the block with its default parameters: a 2-bit divide field, a 5-bit length field and a minimum length of 16. These defaults bring the full set of four prescaler ratios within reach, up to the longest line of 31 × 8 = 248 enables. They also reach the legal-minimum boundary, with 15 refused and 16 accepted. Line periods are measured in clock cycles between strobes, both with a steady enable and with an enable that toggles every cycle. A further case issues a write in the middle of a line to show that it takes effect only at the next line.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
  localparam int unsigned CTRL_W     = 16;
  localparam int unsigned DIV_W      = 2;
  localparam int unsigned LEN_W      = 5;
  localparam int unsigned DIV_LSB    = 8;
  localparam int unsigned LEN_LSB    = 0;
  localparam int unsigned MIN_LEN    = 16;
  localparam int unsigned RST_DIV    = 0;
  localparam int unsigned RST_LEN    = 25;
  localparam int unsigned MAX_RATIO  = 1 << ((1 << DIV_W) - 1);
  localparam int unsigned PRE_W      = (MAX_RATIO > 1) ? $clog2(MAX_RATIO) : 1;
endpackage

// File: rtl/lpg_rst_sync.sv
module lpg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/lpg_ctrl_reg.sv
module lpg_ctrl_reg
  import lpg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] rdata,
  output logic [DIV_W-1:0]  div_q,
  output logic [LEN_W-1:0]  len_q,
  output logic              err_q
);
  logic [DIV_W-1:0] div_d;
  logic [LEN_W-1:0] len_d;
  logic             err_d;
  logic [LEN_W-1:0] len_in;
  logic             len_ok;

  assign len_in = wdata[LEN_LSB +: LEN_W];
  assign len_ok = (len_in >= LEN_W'(MIN_LEN));

  always_comb begin
    div_d = div_q;
    len_d = len_q;
    err_d = err_q;
    if (wr_en) begin
      div_d = wdata[DIV_LSB +: DIV_W];
      if (len_ok) len_d = len_in;
      else        err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_W'(RST_DIV);
      len_q <= LEN_W'(RST_LEN);
      err_q <= 1'b0;
    end else begin
      div_q <= div_d;
      len_q <= len_d;
      err_q <= err_d;
    end
  end

  always_comb begin
    rdata = '0;
    rdata[DIV_LSB +: DIV_W] = div_q;
    rdata[LEN_LSB +: LEN_W] = len_q;
  end

  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    len_q >= LEN_W'(MIN_LEN)); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R5
endmodule

// File: rtl/lpg_prescaler.sv
module lpg_prescaler
  import lpg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_en,
  input  logic             bypass,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic [PRE_W-1:0] lim;

  always_comb begin
    lim = '0;
    if (!bypass) begin
      for (int i = 0; i < PRE_W; i++) lim[i] = (i < int'(div_sel));
    end
  end

  assign tick = osc_en && (pre_q >= lim);

  always_comb begin
    pre_d = pre_q;
    if (osc_en) pre_d = tick ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  AST_TICK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> osc_en); // R9
  AST_BYPASS_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && osc_en) |-> tick); // R7
endmodule

// File: rtl/lpg_line_counter.sv
module lpg_line_counter
  import lpg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [DIV_W-1:0] div_new,
  input  logic [LEN_W-1:0] len_new,
  output logic [DIV_W-1:0] div_act,
  output logic             line_pulse
);
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] len_act_q, len_act_d;
  logic [DIV_W-1:0] div_act_q, div_act_d;
  logic             pulse_d;
  logic             wrap;

  assign wrap = tick && (cnt_q >= len_act_q - 1'b1);

  always_comb begin
    cnt_d     = cnt_q;
    len_act_d = len_act_q;
    div_act_d = div_act_q;
    pulse_d   = wrap;
    if (tick) cnt_d = wrap ? '0 : cnt_q + 1'b1;
    if (wrap) begin
      len_act_d = len_new;
      div_act_d = div_new;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      len_act_q  <= LEN_W'(RST_LEN);
      div_act_q  <= DIV_W'(RST_DIV);
      line_pulse <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      len_act_q  <= len_act_d;
      div_act_q  <= div_act_d;
      line_pulse <= pulse_d;
    end
  end

  assign div_act = div_act_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    line_pulse |=> !line_pulse); // R8
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < len_act_q); // R3
  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(len_act_q) && $stable(div_act_q))); // R6
  AST_PULSE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    line_pulse |-> (cnt_q == '0)); // R8
endmodule

// File: rtl/lpg_top.sv
module lpg_top
  import lpg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        osc_en,
  input  logic        rgb_mode,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        line_pulse,
  output logic        len_err
);
  logic             rst_n_s;
  logic [DIV_W-1:0] div_reg;
  logic [LEN_W-1:0] len_reg;
  logic [DIV_W-1:0] div_act;
  logic             tick;

  lpg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  lpg_ctrl_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n_s),
    .wr_en (reg_wr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .div_q (div_reg),
    .len_q (len_reg),
    .err_q (len_err)
  );

  lpg_prescaler u_pre (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .osc_en  (osc_en),
    .bypass  (rgb_mode),
    .div_sel (div_act),
    .tick    (tick)
  );

  lpg_line_counter u_line (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .tick       (tick),
    .div_new    (div_reg),
    .len_new    (len_reg),
    .div_act    (div_act),
    .line_pulse (line_pulse)
  );
endmodule

// File: tb/sim_lpg_top.sv
module sim_lpg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc_en = 1'b1;
  logic        rgb_mode = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        line_pulse;
  logic        len_err;
  logic        gate_toggle = 1'b0;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  lpg_top u0 (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .rgb_mode(rgb_mode),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .line_pulse(line_pulse), .len_err(len_err)
  );

  always @(negedge clk) if (gate_toggle) osc_en <= ~osc_en;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_pulse(input string req);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!line_pulse && n < 3000);
    if (!line_pulse) check(req, 0, 1);
  endtask

  // Called just after a strobe was sampled; returns cycles to the next strobe.
  task automatic measure(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!line_pulse && n < 3000);
  endtask

  task automatic period_of(input string req, input int exp);
    int n;
    wait_pulse(req);
    wait_pulse(req);
    measure(n);
    check(req, n, exp);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 rdata", int'(reg_rdata), 16'h0019);
    check("R1 err", int'(len_err), 0);
    check("R1 pulse", int'(line_pulse), 0);
    period_of("R1 default period", 25);
  endtask

  task automatic t_layout();
    do_write(16'hFFFF);
    check("R2 all ones", int'(reg_rdata), 16'h031F);
    do_write(16'hFCF1);
    check("R2 masked", int'(reg_rdata), 16'h0011);
  endtask

  task automatic t_periods();
    int n;
    do_write(16'h0010); period_of("R3 len16 div1", 16);
    do_write(16'h001F); period_of("R3 len31 div1", 31);
    do_write(16'h0111); period_of("R4 len17 div2", 34);
    do_write(16'h0210); period_of("R4 len16 div4", 64);
    do_write(16'h031F); period_of("R4 len31 div8", 248);
    wait_pulse("R8");
    @(negedge clk);
    check("R8 strobe width", int'(line_pulse), 0);
    measure(n);
    check("R8 one strobe per line", n, 247);
  endtask

  task automatic t_illegal();
    do_write(16'h0010);
    do_write(16'h020F);
    check("R5 len kept div taken", int'(reg_rdata), 16'h0210);
    check("R5 err set", int'(len_err), 1);
    period_of("R5 period with kept len", 64);
    do_write(16'h0014);
    check("R5 err sticky", int'(len_err), 1);
    check("R5 legal after error", int'(reg_rdata), 16'h0014);
  endtask

  task automatic t_boundary();
    int n;
    do_write(16'h0019);
    wait_pulse("R6");
    wait_pulse("R6");
    n = 0;
    repeat (5) begin @(negedge clk); n++; end
    reg_wr = 1'b1; reg_wdata = 16'h0010;
    @(negedge clk); n++;
    reg_wr = 1'b0;
    while (!line_pulse && n < 3000) begin @(negedge clk); n++; end
    check("R6 current line unchanged", n, 25);
    measure(n);
    check("R6 next line new length", n, 16);
  endtask

  task automatic t_rgb();
    do_write(16'h0314);
    rgb_mode = 1'b1;
    period_of("R7 rgb ignores div", 20);
    rgb_mode = 1'b0;
    period_of("R7 normal div8", 160);
  endtask

  task automatic t_gate();
    do_write(16'h0010);
    period_of("R9 setup", 16);
    gate_toggle = 1'b1;
    period_of("R9 half enable", 32);
    gate_toggle = 1'b0;
    @(negedge clk);
    osc_en = 1'b1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_layout();
    t_periods();
    t_illegal();
    t_boundary();
    t_rgb();
    t_gate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule